// File: doc/BRIEF.md
# 1-Wire Master Read-Slot Sequencer

This block is the bus master's side of a single read time slot on an open-drain 1-Wire line. When idle and given a start request, it pulls the line low for a short programmed interval and then lets go. It keeps counting and takes the bit at a programmed point late in the slave's valid window. After that it holds the slot open until the full slot period has elapsed. It then enforces a separate recovery interval before it will accept another request. The recovery interval can be lengthened for heavily loaded lines.

All intervals are clock-cycle counts given as parameters. There is one set for standard speed and one for overdrive, and the speed is captured when the slot starts. The line input passes through a synchronizer of `SYNC_STAGES` flops (two by default) before it is sampled. So the stored bit reflects the line as it stood `SYNC_STAGES` cycles before the sample edge. A low line yields 0. A high line yields 1, because a slave answering 1 never pulls the line down.

Top module: `ow_read_slot`

## Requirements
- R1: A start request seen while idle makes busy and the pull-down enable rise on the following cycle. The pull-down stays asserted for exactly LOW cycles of the selected speed, counted as slot cycles 0 to LOW-1, and is deasserted in every other cycle.
- R2: The bit is the synchronized line level captured at the end of slot cycle SAMP. With two synchronizer stages this is the line level during slot cycle SAMP-2. A low line gives 0 and a high line gives 1.
- R3: busy stays high for exactly SLOT+REC consecutive cycles: SLOT cycles of slot time followed by REC cycles of recovery. It is low in the cycle after that.
- R4: done is high for exactly one cycle, the last busy cycle, and the received bit is valid in that cycle.
- R5: A start request while busy is ignored. The slot length and the pull-down pattern are unchanged by it.
- R6: speed select 0 chooses the standard interval set and 1 chooses the overdrive set. It is captured only when a slot starts, and changing it during a slot has no effect on that slot.
- R7: After reset, the pull-down, busy and done are low and the received bit reads 1.
- R8: With start held high, the next slot begins after exactly one idle cycle following done. In that cycle busy is low, and in the cycle after it busy and the pull-down are high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one read slot (taken only when idle) |
| speedSel | input | 1 | 0 = standard timing set, 1 = overdrive timing set |
| lineIn | input | 1 | Raw level of the 1-Wire line |
| pullEn | output | 1 | Enable for the external open-drain pull-down |
| rxBit | output | 1 | Bit returned by the slave |
| done | output | 1 | One-cycle pulse at the end of the slot and its recovery |
| busy | output | 1 | Slot or recovery in progress |

## Verification
The bench sweeps the slave's release point across every cycle of the slot at both speeds. Only a release at or before the effective sample cycle may read as 1. A sample point off by one cycle, or a synchronizer of the wrong depth, flips the bit at the edge of the sweep. The bench checks the pull-down width and busy length in every cycle. A counter that ends one cycle early or late shows up there, as does a recovery interval that was dropped. It also raises start and flips the speed in the middle of slots. A design that restarted, or took the new timing set, would change the busy length. The test with start held high catches a design that skips the idle gap or stalls after done.

// File: rtl/ow_rs_pkg.sv
package ow_rs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HOLD,
    ST_REC
  } slotState_t;

  // control -> datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic takeSample;
    logic latchSpeed;
  } rsStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic endLow;
    logic atSample;
    logic endSlot;
    logic endRec;
  } rsFlag_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ow_rs_datapath.sv
module ow_rs_datapath
  import ow_rs_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_STD     = 6,
  parameter int SAMP_STD    = 14,
  parameter int SLOT_STD    = 70,
  parameter int REC_STD     = 6,
  parameter int LOW_OD      = 1,
  parameter int SAMP_OD     = 3,
  parameter int SLOT_OD     = 10,
  parameter int REC_OD      = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  rsStrobe_t strobe,
  input  logic      speedIn,
  input  logic      lineIn,
  output rsFlag_t   flags,
  output logic      rxBit
);

  logic                   speedQ;
  logic [CNT_W-1:0]       cnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       lowT, sampT, slotT, recT;

  // speed captured once per slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  speedQ <= 1'b0;
    else if (strobe.latchSpeed) speedQ <= speedIn;
  end

  always_comb begin
    if (speedQ) begin
      lowT  = CNT_W'(LOW_OD);
      sampT = CNT_W'(SAMP_OD);
      slotT = CNT_W'(SLOT_OD);
      recT  = CNT_W'(REC_OD);
    end else begin
      lowT  = CNT_W'(LOW_STD);
      sampT = CNT_W'(SAMP_STD);
      slotT = CNT_W'(SLOT_STD);
      recT  = CNT_W'(REC_STD);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.clrCnt) cnt <= '0;
    else if (strobe.incCnt) cnt <= cnt + 1'b1;
  end

  assign flags.endLow   = (cnt == lowT - 1'b1);
  assign flags.atSample = (cnt == sampT);
  assign flags.endSlot  = (cnt == slotT - 1'b1);
  assign flags.endRec   = (cnt == recT - 1'b1);

  // line synchronizer, idle level is high
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else if (g == 0) syncQ[g] <= lineIn;
        else syncQ[g] <= syncQ[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rxBit <= 1'b1;
    else if (strobe.takeSample) rxBit <= syncQ[SYNC_STAGES-1];
  end

  assert_sample_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeSample |=> rxBit == $past(syncQ[SYNC_STAGES-1]));

  assert_speed_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchSpeed |=> $stable(speedQ));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incCnt && !strobe.clrCnt) |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/ow_rs_ctrl.sv
module ow_rs_ctrl
  import ow_rs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  rsFlag_t   flags,
  output rsStrobe_t strobe,
  output logic      pullEn,
  output logic      busy,
  output logic      done
);

  slotState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext         = ST_LOW;
          strobe.clrCnt     = 1'b1;
          strobe.latchSpeed = 1'b1;
        end
      end
      ST_LOW: begin
        strobe.incCnt     = 1'b1;
        strobe.takeSample = flags.atSample;
        if (flags.endLow) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        strobe.incCnt     = 1'b1;
        strobe.takeSample = flags.atSample;
        if (flags.endSlot) begin
          stateNext     = ST_REC;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_REC: begin
        strobe.incCnt = 1'b1;
        if (flags.endRec) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign pullEn = (state == ST_LOW);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_REC) && flags.endRec;

  assert_start_opens_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && pullEn));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  assert_pull_in_slot_R1: assert property (@(posedge clk) disable iff (!rstN)
    pullEn |-> (busy && !done));

endmodule

// File: rtl/ow_read_slot.sv
module ow_read_slot
  import ow_rs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_STD     = 6,
  parameter int SAMP_STD    = 14,
  parameter int SLOT_STD    = 70,
  parameter int REC_STD     = 6,
  parameter int LOW_OD      = 1,
  parameter int SAMP_OD     = 3,
  parameter int SLOT_OD     = 10,
  parameter int REC_OD      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic speedSel,
  input  logic lineIn,
  output logic pullEn,
  output logic rxBit,
  output logic done,
  output logic busy
);

  localparam int MAX_T = maxOf(maxOf(SLOT_STD, REC_STD), maxOf(SLOT_OD, REC_OD));
  localparam int CNT_W = $clog2(MAX_T + 1);

  rsStrobe_t strobe;
  rsFlag_t   flags;

  ow_rs_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .flags  (flags),
    .strobe (strobe),
    .pullEn (pullEn),
    .busy   (busy),
    .done   (done)
  );

  ow_rs_datapath #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES),
    .LOW_STD     (LOW_STD),
    .SAMP_STD    (SAMP_STD),
    .SLOT_STD    (SLOT_STD),
    .REC_STD     (REC_STD),
    .LOW_OD      (LOW_OD),
    .SAMP_OD     (SAMP_OD),
    .SLOT_OD     (SLOT_OD),
    .REC_OD      (REC_OD)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .speedIn (speedSel),
    .lineIn  (lineIn),
    .flags   (flags),
    .rxBit   (rxBit)
  );

endmodule

// File: tb/sim_ow_read_slot.sv
module sim_ow_read_slot;

  localparam int CLK_PERIOD = 10;
  localparam int S_LOW = 6,  S_SAMP = 14, S_SLOT = 70, S_REC = 6;
  localparam int O_LOW = 1,  O_SAMP = 3,  O_SLOT = 10, O_REC = 2;
  localparam int SYNC  = 2;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic speedSel = 1'b0;
  logic slaveLow = 1'b0;
  logic lineIn;
  logic pullEn, rxBit, done, busy;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND line: master or slave may pull low
  assign lineIn = !(pullEn || slaveLow);

  ow_read_slot u0 (
    .clk(clk), .rstN(rstN), .start(start), .speedSel(speedSel),
    .lineIn(lineIn), .pullEn(pullEn), .rxBit(rxBit), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One slot; hold = number of leading slot cycles the slave keeps the line low.
  task automatic runSlot(input bit od, input int hold, input bit pokeStart, input bit flipSpeed);
    int lowT  = od ? O_LOW  : S_LOW;
    int sampT = od ? O_SAMP : S_SAMP;
    int slotT = od ? O_SLOT : S_SLOT;
    int recT  = od ? O_REC  : S_REC;
    int total = slotT + recT;
    int eff   = sampT - SYNC;
    bit expBit = !((eff < lowT) || (eff < hold));
    @(negedge clk);
    start = 1'b1; speedSel = od; slaveLow = 1'b0;
    @(negedge clk);
    start = pokeStart;
    if (flipSpeed) speedSel = !od;
    for (int k = 0; k < total; k++) begin
      slaveLow = (k < hold);
      chk(pullEn == (k < lowT), "R1 pull", pullEn, k < lowT);
      chk(busy == 1'b1, pokeStart ? "R5 busy" : (flipSpeed ? "R6 busy" : "R3 busy"), busy, 1);
      chk(done == (k == total - 1), "R4 done", done, k == total - 1);
      if (k == total - 1)
        chk(rxBit == expBit, od ? "R2 bit od" : "R2 bit std", rxBit, expBit);
      @(negedge clk);
    end
    slaveLow = 1'b0;
    chk(busy == 1'b0, "R3 end", busy, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(pullEn == 0, "R7 pull", pullEn, 0);
    chk(busy == 0, "R7 busy", busy, 0);
    chk(done == 0, "R7 done", done, 0);
    chk(rxBit == 1, "R7 bit", rxBit, 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int h = 0; h <= S_SLOT; h++) runSlot(1'b0, h, 1'b0, 1'b0);
    for (int h = 0; h <= O_SLOT; h++) runSlot(1'b1, h, 1'b0, 1'b0);

    // R5 start during busy, R6 speed flip mid-slot
    runSlot(1'b1, 0, 1'b1, 1'b0);
    start = 1'b0;
    runSlot(1'b0, 20, 1'b1, 1'b1);
    start = 1'b0;
    runSlot(1'b1, 5, 1'b0, 1'b1);
    runSlot(1'b0, 0, 1'b0, 1'b1);

    // R8 back-to-back with start held
    runSlot(1'b1, 0, 1'b1, 1'b0);
    @(negedge clk);
    chk(busy == 1 && pullEn == 1, "R8 restart", {busy, pullEn}, 3);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(busy == 0, "R8 idle", busy, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule